// File: doc/BRIEF.md
# Set/Clear/Toggle Register File with Soft-Reset Sequencer

This block is the control register file of a memory-mapped peripheral. Every logical register is reachable at four bus word addresses. One is a plain value port. The other three are atomic alias ports that set, clear or invert only the bits written as 1. Software can therefore change single control bits without a read-modify-write sequence. Reads at any of the four addresses return the register's current contents one cycle after the read strobe.

The two top bits of register 0 control the peripheral core. The top bit is a soft reset. While it is 1, the other registers and the core are held at their reset values. Once it has been 1 for a fixed number of clock cycles, hardware sets the bit below it, the clock gate, so that software can poll for completion. Software then clears the soft reset and afterwards the clock gate, and the core runs again. A small dummy core, a free-running counter, stands in for the peripheral logic. It shows the effect of the reset and gate controls at a port.

Top module: `sct_regfile`

## Requirements
- R1: After `rst`, register 0 reads 0xC0000000 (soft reset and clock gate both 1), every other register reads 0, `core_rst` is 1, `core_clk_en` is 0 and `core_count` is 0.
- R2: The byte address selects the register with bits [ADDR_W-1:4] and the alias with bits [3:2]. A write at alias 0 (offset 0x0) replaces the register value. A read at any alias returns the current value on `rdata` one cycle after `rd_en`.
- R3: A write at alias 1 (offset 0x4) forces to 1 every bit written as 1 and leaves the other bits unchanged.
- R4: A write at alias 2 (offset 0x8) forces to 0 every bit written as 1 and leaves the other bits unchanged.
- R5: A write at alias 3 (offset 0xC) inverts every bit written as 1 and leaves the other bits unchanged.
- R6: While register 0 bit 31 (soft reset) is 1, all registers other than register 0 and bits 29:0 of register 0 are held at 0, and `core_rst` equals that bit.
- R7: When the soft reset has been 1 for RST_DELAY cycles, hardware sets register 0 bit 30 (clock gate). This happens only once per soft-reset period, so a clock gate cleared by software stays cleared while the soft reset remains 1.
- R8: While the clock gate is 1, writes to registers other than register 0 are ignored. Register 0 remains writable.
- R9: `core_clk_en` is the inverse of the clock gate. `core_count` is 0 during soft reset, advances by one each cycle while enabled and out of reset, and holds while gated.
- R10: `rdata` changes only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address: register index and alias select |
| wdata | input | DATA_W | Write data or bit mask |
| rdata | output | DATA_W | Registered read data |
| core_rst | output | 1 | Reset to the peripheral core (soft-reset bit) |
| core_clk_en | output | 1 | Clock enable to the peripheral core |
| core_count | output | CORE_W | Dummy core state |

## Verification
The alias logic is driven with random register indices, alias selectors and data words and is compared against a bench model. Dense masks show whether bits outside the mask stay unchanged. Repeated toggles of the same bits separate a true inversion from a set or a clear. Directed sequences then follow the full soft-reset handshake. They show that the gate appears neither early nor late, that it does not reassert after software clears it, that gated writes are dropped while register 0 still accepts writes, and that the core counter freezes, clears and resumes at the expected cycles.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [1:0] {
    AL_VALUE  = 2'd0,
    AL_SET    = 2'd1,
    AL_CLEAR  = 2'd2,
    AL_TOGGLE = 2'd3
  } alias_e;
endpackage

// File: rtl/sct_alias_decode.sv
module sct_alias_decode
  import sct_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2,
  parameter int ADDR_W   = IDX_W + 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output alias_e            op,
  output logic              hit
);
  always_comb begin
    idx = addr[ADDR_W-1:4];
    op  = alias_e'(addr[3:2]);
    hit = (int'(addr[ADDR_W-1:4]) < NUM_REGS);
  end
endmodule

// File: rtl/sct_reset_seq.sv
module sct_reset_seq #(
  parameter int RST_DELAY = 16,
  localparam int CNT_W    = $clog2(RST_DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  output logic gate_set
);
  logic [CNT_W-1:0] cnt;
  logic             done;

  assign gate_set = soft_rst && !done && (cnt == CNT_W'(RST_DELAY - 1));

  always_ff @(posedge clk) begin
    if (rst || !soft_rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (gate_set) done <= 1'b1;
      else          cnt  <= cnt + 1'b1;
    end
  end

  // R7: completion is flagged once, then the sequencer stays quiet
  a_r7_done_after_set: assert property (@(posedge clk) disable iff (rst)
    gate_set && soft_rst |=> done);
  a_r7_one_shot: assert property (@(posedge clk) disable iff (rst)
    done |-> !gate_set);
  a_r7_idle_when_released: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> !done);
endmodule

// File: rtl/sct_core_model.sv
module sct_core_model #(
  parameter int CORE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_rst,
  input  logic              clk_en,
  output logic [CORE_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || core_rst) count <= '0;
    else if (clk_en)     count <= count + 1'b1;
  end

  // R9: a gated core holds its state
  a_r9_gated_hold: assert property (@(posedge clk) disable iff (rst)
    !clk_en && !core_rst |=> $stable(count));
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> count == '0);
endmodule

// File: rtl/sct_regfile.sv
module sct_regfile
  import sct_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 4,
  parameter int RST_DELAY = 16,
  parameter int CORE_W    = 16,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W   = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              core_rst,
  output logic              core_clk_en,
  output logic [CORE_W-1:0] core_count
);
  localparam int SFT_BIT  = DATA_W - 1;
  localparam int GATE_BIT = DATA_W - 2;
  localparam logic [DATA_W-1:0] REG0_INIT = {2'b11, {(DATA_W-2){1'b0}}};
  localparam logic [DATA_W-1:0] TOP_MASK  = REG0_INIT;

  logic [DATA_W-1:0] bank     [NUM_REGS];
  logic [DATA_W-1:0] bank_nxt [NUM_REGS];
  logic [IDX_W-1:0]  dec_idx;
  alias_e            dec_op;
  logic              dec_hit;
  logic              gate_set;
  logic              sft_now, gate_now;

  assign sft_now  = bank[0][SFT_BIT];
  assign gate_now = bank[0][GATE_BIT];

  sct_alias_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_decode (
    .addr (addr),
    .idx  (dec_idx),
    .op   (dec_op),
    .hit  (dec_hit)
  );

  sct_reset_seq #(.RST_DELAY(RST_DELAY)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (sft_now),
    .gate_set (gate_set)
  );

  function automatic logic [DATA_W-1:0] apply_alias(
    input logic [DATA_W-1:0] cur, input alias_e op, input logic [DATA_W-1:0] d);
    case (op)
      AL_SET:    return cur | d;
      AL_CLEAR:  return cur & ~d;
      AL_TOGGLE: return cur ^ d;
      default:   return d;
    endcase
  endfunction

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) begin
      bank_nxt[k] = bank[k];
      if (wr_en && dec_hit && (int'(dec_idx) == k))
        bank_nxt[k] = apply_alias(bank[k], dec_op, wdata);
      if (k == 0) begin
        if (gate_set) bank_nxt[0][GATE_BIT] = 1'b1;
        if (sft_now)  bank_nxt[0] = bank_nxt[0] & TOP_MASK;
      end else begin
        if (sft_now)       bank_nxt[k] = '0;
        else if (gate_now) bank_nxt[k] = bank[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) bank[k] <= (k == 0) ? REG0_INIT : '0;
    end else begin
      for (int k = 0; k < NUM_REGS; k++) bank[k] <= bank_nxt[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_en)  rdata <= dec_hit ? bank[dec_idx] : '0;
  end

  assign core_rst    = sft_now;
  assign core_clk_en = !gate_now;

  sct_core_model #(.CORE_W(CORE_W)) i_core (
    .clk      (clk),
    .rst      (rst),
    .core_rst (core_rst),
    .clk_en   (core_clk_en),
    .count    (core_count)
  );

  // R10: read data only moves after a strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R7: the gate only rises through the sequencer or a bus write to register 0
  a_r7_gate_source: assert property (@(posedge clk) disable iff (rst)
    !gate_now && !gate_set && !(wr_en && dec_hit && dec_idx == '0) |=> !gate_now);

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_chk
    // R6: soft reset clears the other registers
    a_r6_held_zero: assert property (@(posedge clk) disable iff (rst)
      sft_now |=> bank[g] == '0);
    // R8: gated writes are dropped
    a_r8_gated_write: assert property (@(posedge clk) disable iff (rst)
      wr_en && dec_hit && int'(dec_idx) == g && gate_now && !sft_now |=> $stable(bank[g]));
  end
endmodule

// File: tb/test_sct_regfile.sv
module test_sct_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32, NUM_REGS = 4, RST_DELAY = 16, CORE_W = 16;
  localparam int ADDR_W = 6;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic core_rst, core_clk_en;
  logic [CORE_W-1:0] core_count;

  int n_checks = 0, n_fail = 0;
  logic [31:0] exp_reg [NUM_REGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sct_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RST_DELAY(RST_DELAY), .CORE_W(CORE_W))
    i_sct_regfile (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .core_rst(core_rst),
                   .core_clk_en(core_clk_en), .core_count(core_count));

  function automatic logic [31:0] model(input logic [31:0] cur, input int op, input logic [31:0] d);
    case (op)
      1: return cur | d;
      2: return cur & ~d;
      3: return cur ^ d;
      default: return d;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input int op, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = ADDR_W'(r * 16 + op * 4); wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int r, input int op, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = ADDR_W'(r * 16 + op * 4);
    @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [CORE_W-1:0] c0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 core_rst", 32'(core_rst), 1);
    check("R1 core_clk_en", 32'(core_clk_en), 0);
    check("R1 core_count", 32'(core_count), 0);
    rd(0, 0, v); check("R1 reg0", v, 32'hC000_0000);
    rd(2, 0, v); check("R1 reg2", v, 0);
    // R6: register writes during soft reset do not stick
    wr(1, 0, 32'h1234_5678);
    rd(1, 0, v); check("R6 held during soft reset", v, 0);
    idle(RST_DELAY + 2);
    // R4 R6: release soft reset, gate still set
    wr(0, 2, 32'h8000_0000);
    rd(0, 3, v); check("R4 clear soft reset", v, 32'h4000_0000);
    check("R6 core_rst released", 32'(core_rst), 0);
    // R8 R9: gated writes ignored, core frozen
    wr(1, 0, 32'hDEAD_BEEF);
    rd(1, 0, v); check("R8 gated write ignored", v, 0);
    c0 = core_count; idle(4);
    check("R9 gated core holds", 32'(core_count), 32'(c0));
    wr(0, 1, 32'h0000_0005);
    rd(0, 0, v); check("R8 reg0 writable while gated", v, 32'h4000_0005);
    wr(0, 2, 32'h4000_0005);
    rd(0, 1, v); check("R4 clear gate", v, 0);
    check("R9 clk_en after ungate", 32'(core_clk_en), 1);
    c0 = core_count; idle(5);
    check("R9 core advances", 32'(core_count), 32'(c0) + 5);
    // R10: rdata holds without strobe
    v = rdata; idle(3); check("R10 rdata stable", rdata, v);
    // directed alias corners
    for (int r = 0; r < NUM_REGS; r++) exp_reg[r] = 0;
    wr(2, 0, 32'hFFFF_0000); exp_reg[2] = 32'hFFFF_0000;
    rd(2, 2, v); check("R2 value write, read at clear alias", v, exp_reg[2]);
    wr(2, 1, 32'h0000_00FF); exp_reg[2] = 32'hFFFF_00FF;
    rd(2, 0, v); check("R3 set alias", v, exp_reg[2]);
    wr(2, 2, 32'h0F0F_0F0F); exp_reg[2] = 32'hF0F0_00F0;
    rd(2, 0, v); check("R4 clear alias", v, exp_reg[2]);
    wr(2, 3, 32'hFFFF_FFFF); exp_reg[2] = 32'h0F0F_FF0F;
    rd(2, 0, v); check("R5 toggle alias", v, exp_reg[2]);
    wr(2, 3, 32'hFFFF_FFFF); exp_reg[2] = 32'hF0F0_00F0;
    rd(2, 0, v); check("R5 toggle twice", v, exp_reg[2]);
    // random alias traffic
    for (int it = 0; it < 300; it++) begin
      int r, op;
      logic [31:0] d;
      r = $urandom_range(0, NUM_REGS - 1);
      op = $urandom_range(0, 3);
      d = $urandom;
      if (r == 0) d[31:30] = 2'b00;
      wr(r, op, d);
      exp_reg[r] = model(exp_reg[r], op, d);
      r = $urandom_range(0, NUM_REGS - 1);
      rd(r, $urandom_range(0, 3), v);
      case ($urandom_range(0, 3))
        0: check("R2 random read", v, exp_reg[r]);
        1: check("R3 random read", v, exp_reg[r]);
        2: check("R4 random read", v, exp_reg[r]);
        default: check("R5 random read", v, exp_reg[r]);
      endcase
    end
    // R6 R7: soft reset sequence
    wr(3, 0, 32'hA5A5_A5A5);
    wr(0, 1, 32'h8000_0000);
    check("R6 core_rst follows bit", 32'(core_rst), 1);
    idle(RST_DELAY / 2);
    rd(0, 0, v); check("R7 gate not yet set", v, 32'h8000_0000);
    rd(3, 0, v); check("R6 reg3 cleared", v, 0);
    check("R6 core_count cleared", 32'(core_count), 0);
    idle(RST_DELAY);
    rd(0, 0, v); check("R7 gate set after delay", v, 32'hC000_0000);
    check("R9 clk_en low when gated", 32'(core_clk_en), 0);
    wr(0, 2, 32'h4000_0000);
    idle(RST_DELAY + 4);
    rd(0, 0, v); check("R7 gate not reasserted", v, 32'h8000_0000);
    wr(0, 2, 32'h8000_0000);
    rd(0, 0, v); check("R7 clean exit", v, 0);
    wr(1, 0, 32'h0000_1111);
    rd(1, 0, v); check("R8 write accepted after ungate", v, 32'h0000_1111);
    c0 = core_count; idle(3);
    check("R9 core runs after sequence", 32'(core_count), 32'(c0) + 3);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule